// File: doc/BRIEF.md
# Single-Wire Debug Bit Transceiver

This block is the target-side bit engine of a one-wire background debug link. The link has a single shared line with a weak pull-up. The host starts every bit with a falling edge, in both directions. The block brings that asynchronous line into its clock domain and finds each host falling edge. It then runs a self-timed bit slot counted in target ticks, where one target tick is one clock enable in every eight input clocks.

When receiving, the block samples the line partway through the slot and shifts the bit in, most significant bit first. When transmitting, it either holds the line low for a 0, or releases the line for a 1 and adds a short active-high speedup pulse so the line does not wait on a slow RC rise. The block exchanges whole bytes or 16-bit words with a command layer. It raises a completion strobe after the last bit. If the host goes quiet in the middle of a transfer, it drops the partial transfer.

Top module: `dbgw_phy`

## Requirements
- R1: While reset is held and right after it is released, `pad_oe`, `pad_out`, `done`, `timeout` and `rx_data` are all 0.
- R2: `line_in` passes through two flops. A slot starts only on a high-to-low change of the synchronized line seen while no slot is running. A falling edge inside a running slot is ignored, so that bit is counted once and keeps the value sampled at tick 10.
- R3: A target tick comes once every 8 clocks, and a slot lasts 16 ticks. Because of this the speedup pulse is exactly 16 clocks long, and a driven 0 lasts between 97 and 104 clocks.
- R4: With `mode_tx`=0 at the slot start, the synchronized line is sampled on the 10th tick of the slot and shifted into bit 0 of the shift register. The pad is never enabled during such a slot.
- R5: In a transmit slot carrying a 0, `pad_oe`=1 and `pad_out`=0 from the clock after the edge is detected until the 13th tick of the slot.
- R6: In a transmit slot carrying a 1, the pad is released except during ticks 7 and 8 of the slot, when `pad_oe`=1 and `pad_out`=1 (the speedup pulse). A 0 slot never raises `pad_out`.
- R7: A `tx_load` pulse copies `tx_data` into the shift register and restarts the bit count. The transmit slots then send bit 7 first in byte mode or bit 15 first in word mode, down to bit 0.
- R8: `size_word`=0 selects 8-bit transfers and `size_word`=1 selects 16-bit transfers. `done` is a one-clock strobe in the clock after the last bit is sampled. In byte mode the upper 8 bits of `rx_data` read 0.
- R9: Suppose a transfer is partial or a slot is running, and 512 ticks pass with no accepted falling edge. Then `timeout` pulses for one clock, and the shift register and bit count are cleared: `rx_data` reads 0 and the next bit starts a fresh transfer.
- R10: If an edge is accepted in the same clock as the timeout would expire, the edge wins. No `timeout` pulse occurs, and the bit joins the partial transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw level of the shared debug line |
| mode_tx | input | 1 | 1: the next slot transmits, 0: it receives |
| size_word | input | 1 | 0: 8-bit transfer, 1: 16-bit transfer |
| tx_load | input | 1 | One-clock pulse that loads `tx_data` |
| tx_data | input | 16 | Byte or word to transmit |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value while enabled |
| rx_data | output | 16 | Received byte (zero-extended) or word |
| done | output | 1 | One-clock strobe: the transfer is complete |
| timeout | output | 1 | One-clock strobe: the partial transfer was dropped |

## Verification
Two functions can fall in the same clock: the idle timeout expiring, and a new host edge being accepted. The bench sends three bits, then stays silent for a gap that it sweeps one clock at a time across the 16 clocks around the expiry point, and then sends the byte 0xA5. Each trial is judged by the outcome visible at the ports. If `timeout` pulsed, the byte must arrive whole as 0xA5. If it did not, the edge won, and the first completed byte must be 0xB4 (the three old bits followed by five new ones). The sweep must produce both outcomes.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } dir_e;

   typedef enum logic {
      XFER_BYTE = 1'b0,
      XFER_WORD = 1'b1
   } xfer_e;
endpackage

// File: rtl/dbgw_tick_div.sv
module dbgw_tick_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt <= '0;
         else if (cnt == CW'(DIV - 1))   cnt <= '0;
         else                            cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
   end
endmodule

// File: rtl/dbgw_edge_sync.sv
module dbgw_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_s,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_raw};
         prev  <= chain[STAGES-1];
      end
   end

   assign line_s = chain[STAGES-1];
   assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/dbgw_slot_timer.sv
module dbgw_slot_timer #(
   parameter int BIT_TICKS     = 16,
   parameter int TIMEOUT_TICKS = 512,
   localparam int PH_W = $clog2(BIT_TICKS),
   localparam int TO_W = $clog2(TIMEOUT_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            start,
   input  logic            busy,
   output logic            active,
   output logic [PH_W-1:0] phase,
   output logic            expire
);
   if (TIMEOUT_TICKS <= BIT_TICKS) begin : g_bad_to
      $error("TIMEOUT_TICKS must exceed BIT_TICKS");
   end

   logic [TO_W-1:0] idle_cnt;
   logic            watching;

   assign watching = active | busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
      end else if (start) begin
         active <= 1'b1;
         phase  <= '0;
      end else if (tick && active) begin
         if (phase == PH_W'(BIT_TICKS - 1)) begin
            active <= 1'b0;
            phase  <= '0;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      idle_cnt <= '0;
      else if (start || !watching)     idle_cnt <= '0;
      else if (tick) begin
         if (idle_cnt == TO_W'(TIMEOUT_TICKS - 1)) idle_cnt <= '0;
         else                                      idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign expire = tick & watching & ~start &
                   (idle_cnt == TO_W'(TIMEOUT_TICKS - 1));
endmodule

// File: rtl/dbgw_phy.sv
module dbgw_phy
   import dbgw_pkg::*;
#(
   parameter int CLK_DIV       = 8,
   parameter int BIT_TICKS     = 16,
   parameter int SAMPLE_TICK   = 10,
   parameter int DRIVE0_END    = 13,
   parameter int BOOST_START   = 7,
   parameter int BOOST_LEN     = 2,
   parameter int TIMEOUT_TICKS = 512,
   parameter int SYNC_STAGES   = 2,
   parameter int BYTE_W        = 8,
   parameter int WORD_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              mode_tx,
   input  logic              size_word,
   input  logic              tx_load,
   input  logic [WORD_W-1:0] tx_data,
   output logic              pad_oe,
   output logic              pad_out,
   output logic [WORD_W-1:0] rx_data,
   output logic              done,
   output logic              timeout
);
   localparam int PH_W  = $clog2(BIT_TICKS);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_TICK - 1);
   localparam logic [PH_W-1:0] PH_D0_END = PH_W'(DRIVE0_END);
   localparam logic [PH_W-1:0] PH_B_LO   = PH_W'(BOOST_START);
   localparam logic [PH_W-1:0] PH_B_HI   = PH_W'(BOOST_START + BOOST_LEN);

   if (SAMPLE_TICK < 1 || SAMPLE_TICK >= BIT_TICKS || DRIVE0_END >= BIT_TICKS ||
       BOOST_START + BOOST_LEN >= BIT_TICKS || BOOST_LEN < 1) begin : g_bad_timing
      $error("slot timing points must lie inside the bit slot");
   end
   if (BYTE_W < 2 || WORD_W < BYTE_W) begin : g_bad_width
      $error("WORD_W must be at least BYTE_W, and BYTE_W at least 2");
   end

   logic            tick, line_s, fall, fall_acc;
   logic            active, expire, sample_ev;
   logic [PH_W-1:0] phase;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  last_bit;
   logic [IDX_W-1:0]  msb_idx;
   logic              cur_bit;
   dir_e              slot_dir;
   logic              slot_is_tx;

   dbgw_tick_div #(.DIV(CLK_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   dbgw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_raw(line_in), .line_s(line_s), .fall(fall));

   dbgw_slot_timer #(.BIT_TICKS(BIT_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(fall_acc),
      .busy(bit_cnt != '0), .active(active), .phase(phase), .expire(expire));

   assign fall_acc  = fall & ~active;
   assign sample_ev = active & tick & (phase == PH_SAMPLE);
   assign last_bit  = (xfer_e'(size_word) == XFER_WORD) ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
   assign msb_idx   = (xfer_e'(size_word) == XFER_WORD) ? IDX_W'(WORD_W - 1) : IDX_W'(BYTE_W - 1);
   assign slot_is_tx = (slot_dir == DIR_TX);

   // Direction and transmitted bit are captured at every accepted edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_dir <= DIR_RX;
         cur_bit  <= 1'b0;
      end else if (fall_acc) begin
         slot_dir <= dir_e'(mode_tx);
         cur_bit  <= shreg[msb_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
         done    <= 1'b0;
         timeout <= 1'b0;
      end else begin
         done    <= 1'b0;
         timeout <= expire;
         if (expire) begin
            shreg   <= '0;
            bit_cnt <= '0;
         end else if (tx_load) begin
            shreg   <= tx_data;
            bit_cnt <= '0;
         end else begin
            if (fall_acc && mode_tx)
               shreg <= shreg << 1;
            if (sample_ev) begin
               if (!slot_is_tx)
                  shreg <= {shreg[WORD_W-2:0], line_s};
               if (bit_cnt == last_bit) begin
                  bit_cnt <= '0;
                  done    <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

   // Pseudo open-drain drive: low for a 0, short high boost for a 1.
   logic in_low_win, in_boost_win;
   assign in_low_win   = (phase < PH_D0_END);
   assign in_boost_win = (phase >= PH_B_LO) && (phase < PH_B_HI);
   assign pad_oe  = active & slot_is_tx & (cur_bit ? in_boost_win : in_low_win);
   assign pad_out = active & slot_is_tx & cur_bit & in_boost_win;

   if (WORD_W > BYTE_W) begin : g_rx_mask
      assign rx_data = (xfer_e'(size_word) == XFER_WORD) ? shreg :
                       {{(WORD_W-BYTE_W){1'b0}}, shreg[BYTE_W-1:0]};
   end else begin : g_rx_direct
      assign rx_data = shreg;
   end
endmodule

// File: rtl/dbgw_phy_chk.sv
module dbgw_phy_chk #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pad_oe,
   input logic              pad_out,
   input logic              done,
   input logic              timeout,
   input logic [WORD_W-1:0] rx_data,
   input logic              slot_is_tx,
   input logic              active,
   input logic              fall,
   input logic [CNT_W-1:0]  bit_cnt
);
   assert_slot_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(fall));

   assert_rx_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_is_tx |-> !pad_oe);

   assert_boost_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_out) |=> pad_out);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_timeout_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (bit_cnt == '0 && rx_data == '0 && !done));

   assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !active) |=> !timeout);
endmodule

bind dbgw_phy dbgw_phy_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .pad_out(pad_out), .done(done),
   .timeout(timeout), .rx_data(rx_data), .slot_is_tx(slot_is_tx),
   .active(active), .fall(fall), .bit_cnt(bit_cnt));

// File: tb/dbgw_phy_test.sv
`timescale 1ns/1ps
module dbgw_phy_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_low = 1'b0;
   logic        mode_tx = 1'b0, size_word = 1'b0, tx_load = 1'b0;
   logic [15:0] tx_data = '0;
   logic        line_in, pad_oe, pad_out, done, timeout;
   logic [15:0] rx_data;

   always #2.5 clk = ~clk;

   dbgw_phy uut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .mode_tx(mode_tx),
      .size_word(size_word), .tx_load(tx_load), .tx_data(tx_data),
      .pad_oe(pad_oe), .pad_out(pad_out), .rx_data(rx_data),
      .done(done), .timeout(timeout));

   // Shared line: host pulls low, target drives when enabled, else pull-up.
   assign line_in = host_low ? 1'b0 : (pad_oe ? pad_out : 1'b1);

   int n_chk = 0, n_bad = 0;
   int done_cnt = 0, to_cnt = 0;
   logic [15:0] rx_cap = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            done_cnt++;
            rx_cap = rx_data;
         end
         if (timeout) to_cnt++;
      end
   end

   // {tx, word, glitch, data}
   localparam logic [18:0] VECS [8] = '{
      {1'b0, 1'b0, 1'b0, 16'h00A5},
      {1'b0, 1'b0, 1'b1, 16'h003C},
      {1'b0, 1'b1, 1'b0, 16'hDEAD},
      {1'b0, 1'b1, 1'b1, 16'h8001},
      {1'b1, 1'b0, 1'b0, 16'h00A5},
      {1'b1, 1'b0, 1'b0, 16'h0080},
      {1'b1, 1'b1, 1'b0, 16'h3C96},
      {1'b1, 1'b0, 1'b0, 16'hFF7E}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; host_low = 1'b0; tx_load = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      done_cnt = 0; to_cnt = 0;
   endtask

   // One host bit period of 160 clocks (20 ticks).
   task automatic host_bit(input logic val, input logic glitch,
                           output logic seen, output int lo, output int hi);
      lo = 0; hi = 0; seen = 1'b1;
      for (int i = 0; i < 160; i++) begin
         @(negedge clk);
         if (i == 0) host_low = 1'b1;
         if (i == ((mode_tx || val) ? 32 : 104)) host_low = 1'b0;
         if (glitch && val && i == 40) host_low = 1'b1;
         if (glitch && val && i == 44) host_low = 1'b0;
         if (i == 90) seen = line_in;
         if (pad_oe && !pad_out) lo++;
         if (pad_oe && pad_out) hi++;
      end
   endtask

   task automatic send_rx(input logic [15:0] d, input int nbits, input logic glitch);
      logic s; int lo, hi;
      for (int b = nbits - 1; b >= 0; b--) begin
         host_bit(d[b], glitch, s, lo, hi);
         check("R4 pad idle in receive", lo + hi, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic s; int lo, hi; int d0, ws_to, ws_edge;
      // R1: reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 pad_oe in reset", pad_oe, 0);
      check("R1 rx_data in reset", rx_data, 0);
      do_reset();
      @(negedge clk);
      check("R1 pad_oe/pad_out after reset", {pad_oe, pad_out}, 0);
      check("R1 done/timeout after reset", {done, timeout}, 0);
      check("R1 rx_data after reset", rx_data, 0);

      // Table walk: R2 R3 R4 R5 R6 R7 R8
      foreach (VECS[v]) begin
         logic tx, wd, gl; logic [15:0] dat; int nb;
         {tx, wd, gl, dat} = VECS[v];
         nb = wd ? 16 : 8;
         @(negedge clk);
         mode_tx = tx; size_word = wd;
         d0 = done_cnt;
         if (tx) begin
            tx_data = dat; tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
            for (int b = nb - 1; b >= 0; b--) begin
               host_bit(1'b0, 1'b0, s, lo, hi);
               check("R7 transmitted bit order", s, dat[b]);
               if (dat[b]) begin
                  check("R6 one bit not held low", lo, 0);
                  check("R3 R6 speedup pulse length", hi, 16);
               end else begin
                  check("R6 zero bit never driven high", hi, 0);
                  check_rng("R3 R5 zero hold length", lo, 97, 104);
               end
            end
            check("R8 done once per transmitted transfer", done_cnt - d0, 1);
         end else begin
            send_rx(dat, nb, gl);
            check("R2 R8 done once per received transfer", done_cnt - d0, 1);
            check("R4 R8 received value", rx_cap, wd ? dat : {8'h00, dat[7:0]});
         end
      end

      // R9: timeout drops a partial transfer
      do_reset();
      mode_tx = 1'b0; size_word = 1'b0;
      send_rx(16'h0007, 3, 1'b0);
      repeat (5000) @(negedge clk);
      check("R9 one timeout pulse", to_cnt, 1);
      check("R9 no done from partial", done_cnt, 0);
      check("R9 rx_data cleared", rx_data, 0);
      send_rx(16'h005A, 8, 1'b0);
      check("R9 fresh transfer after timeout", done_cnt, 1);
      check("R9 fresh transfer value", rx_cap, 16'h005A);

      // R10: sweep host edge across the expiry clock
      ws_to = 0; ws_edge = 0;
      for (int w = 4086; w <= 4101; w++) begin
         do_reset();
         mode_tx = 1'b0; size_word = 1'b0;
         send_rx(16'h0005, 3, 1'b0);
         repeat (w - 160) @(negedge clk);
         send_rx(16'h00A5, 8, 1'b0);
         if (to_cnt == 1) begin
            ws_to++;
            check("R10 timeout side: whole new byte", {done_cnt[7:0], rx_cap}, {8'd1, 16'h00A5});
         end else begin
            ws_edge++;
            check("R10 edge side: no timeout", to_cnt, 0);
            check("R10 edge side: byte joins partial", {done_cnt[7:0], rx_cap}, {8'd1, 16'h00B4});
         end
      end
      check("R10 sweep reached timeout outcome", ws_to > 0, 1);
      check("R10 sweep reached edge-wins outcome", ws_edge > 0, 1);

      summary();
      $finish;
   end
endmodule